// File: doc/BRIEF.md
# Bytewide Asynchronous SRAM Access Controller

This block models an 8192-word by 8-bit static memory behind an asynchronous bytewide interface. It has a 13-bit address, an 8-bit data path and three active-low strobes: chip enable, write enable and output enable. The strobes are sampled by a fast system clock. From the sampled values the block decodes read and write windows and stores bytes in its internal array. It also decides in which cycles the data drivers are on.

The bidirectional data bus is split at the port list. `dataIn` carries the bus value into the block. `dataOut` together with `dataDrive` form the driver side, and a pad ring turns them into a tri-state pin. When the drivers are released, `dataOut` is held at zero.

A supply supervisor drives `wrProtect`. While it is high, every strobe is ignored, nothing is written and the drivers stay off.

A new write that opens too soon after write enable has risen is rejected. It raises a one-cycle protocol-error pulse.

Top module: `byte_sram_ctl`

## Requirements
- R1: With `wrProtect`=0, `ceN`=0, `oeN`=0 and `weN`=1, the block returns the stored byte of `addrIn`. The second clock edge after the inputs are applied sets `dataDrive`=1, and `dataOut` then equals the last byte written to that address.
- R2: A write window is open while `ceN` and `weN` are both low. The window opens at the later of their falls and closes at the earlier of their rises. When it closes, the address and data sampled in its last open cycle are stored. A window that closes through chip enable stores the same way as one that closes through write enable.
- R3: While a write window is open, `dataDrive` is 0 even when `oeN` is low.
- R4: When `oeN` is high, or `ceN` is high, `dataDrive` is 0 and `dataOut` is 8'h00.
- R5: While `wrProtect` is high, no byte is written, `dataDrive` is 0 and `protoErr` stays 0, whatever the strobes do.
- R6: When `weN` rises, a recovery interval of REC_CYC (3) cycles starts. A write window that opens while `weN` has been high for REC_CYC or fewer clock edges gives a single-cycle `protoErr` pulse and stores nothing. A window opened after REC_CYC+1 or more edges writes normally.
- R7: If `wrProtect` goes high at any point while a window is open, that window is aborted. It stays aborted until it closes, even if protection is removed while it is still open.
- R8: If the data changes while a window is open, the value present in the last open cycle is the one stored.
- R9: All 8192 addresses, including 0 and 8191, hold independent bytes.
- R10: After reset, `dataDrive`=0, `dataOut`=8'h00 and `protoErr`=0, and the recovery interval is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low reset |
| addrIn | input | 13 | Byte address |
| dataIn | input | 8 | Bus value seen by the block |
| ceN | input | 1 | Chip enable, active low |
| weN | input | 1 | Write enable, active low |
| oeN | input | 1 | Output enable, active low |
| wrProtect | input | 1 | Supply-fail write protect, active high |
| dataOut | output | 8 | Read data toward the pad, zero when released |
| dataDrive | output | 1 | Turns on the data drivers |
| protoErr | output | 1 | One-cycle pulse on a write rejected for recovery |

## Verification
Every cycle, the assertions check three things at the ports. The drivers are off two edges after write protect, after an open write window, and after output enable is high. A protocol-error pulse never lasts two cycles, and a rejected window never arms a write.

Other behaviours only show in the bench's scenarios, which read back stored bytes afterwards. These are the following:
- reads returning the last byte written;
- which data value a window stores;
- the abort of a window hit by protection;
- the exact boundary of the recovery interval;
- independence of the end addresses.

// File: rtl/sram_pkg.sv
package sram_pkg;
  // strobes from control to datapath, valid in the cycle they are set
  typedef struct packed {
    logic holdEn;  // window open and unprotected: track address and data
    logic commit;  // window just closed cleanly: store the held byte
    logic drive;   // read conditions met: enable the drivers next cycle
  } memStrobe_t;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int REC_CYC = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       weN,
  input  logic       oeN,
  input  logic       wrProtect,
  output memStrobe_t strb,
  output logic       protoErr
);
  localparam int CNT_W = $clog2(REC_CYC + 1);

  logic ceS, weS, oeS, wpS;
  logic rawWinPrev, weSPrev, inWrite;
  logic [CNT_W-1:0] recCnt;
  logic rawWin, winStart, recBusy, weRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceS <= 1'b1;
      weS <= 1'b1;
      oeS <= 1'b1;
      wpS <= 1'b0;
    end else begin
      ceS <= ceN;
      weS <= weN;
      oeS <= oeN;
      wpS <= wrProtect;
    end
  end

  assign rawWin   = !ceS && !weS;
  assign winStart = rawWin && !rawWinPrev;
  assign recBusy  = (recCnt != '0);
  assign weRise   = weS && !weSPrev;

  always_comb begin
    strb.holdEn = rawWin && !wpS;
    strb.commit = inWrite && !rawWin && !wpS;
    strb.drive  = !ceS && !oeS && weS && !wpS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawWinPrev <= 1'b0;
      weSPrev    <= 1'b1;
      inWrite    <= 1'b0;
      recCnt     <= '0;
      protoErr   <= 1'b0;
    end else begin
      rawWinPrev <= rawWin;
      weSPrev    <= weS;
      if (wpS || !rawWin)  inWrite <= 1'b0;
      else if (winStart)   inWrite <= !recBusy;
      if (weRise)          recCnt <= CNT_W'(REC_CYC);
      else if (recBusy)    recCnt <= recCnt - 1'b1;
      protoErr <= winStart && recBusy && !wpS;
    end
  end

  // R6: a rejected window never arms a write
  p_err_blocks_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> !inWrite);
  // R5: protection sampled means no write armed in the following cycle
  p_protect_disarms_r5: assert property (@(posedge clk) disable iff (!rstN)
    wpS |=> !inWrite);
endmodule

// File: rtl/sram_store.sv
module sram_store
  import sram_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  memStrobe_t        strb,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataDrive
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] addrS, addrHold;
  logic [DATA_W-1:0] dataS, dataHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrS     <= '0;
      dataS     <= '0;
      addrHold  <= '0;
      dataHold  <= '0;
      dataOut   <= '0;
      dataDrive <= 1'b0;
    end else begin
      addrS <= addrIn;
      dataS <= dataIn;
      if (strb.holdEn) begin
        addrHold <= addrS;
        dataHold <= dataS;
      end
      dataDrive <= strb.drive;
      dataOut   <= strb.drive ? mem[addrS] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.commit) mem[addrHold] <= dataHold;
  end

  // R4: a released bus never carries data
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    !dataDrive |-> dataOut == '0);
endmodule

// File: rtl/byte_sram_ctl.sv
module byte_sram_ctl
  import sram_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  parameter int REC_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic              wrProtect,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataDrive,
  output logic              protoErr
);
  memStrobe_t strb;

  sram_ctrl #(.REC_CYC(REC_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN),
    .wrProtect(wrProtect), .strb(strb), .protoErr(protoErr)
  );

  sram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .dataIn(dataIn),
    .strb(strb), .dataOut(dataOut), .dataDrive(dataDrive)
  );

  p_protect_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrProtect |-> ##2 !dataDrive);
  p_write_no_drive_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!ceN && !weN) |-> ##2 !dataDrive);
  p_oe_high_release_r4: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> ##2 !dataDrive);
  p_err_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> !protoErr);
endmodule

// File: tb/sim_byte_sram_ctl.sv
module sim_byte_sram_ctl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [12:0] addrIn = '0;
  logic [7:0]  dataIn = '0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1, wrProtect = 1'b0;
  logic [7:0]  dataOut;
  logic dataDrive, protoErr;

  int total = 0, bad = 0, errPulses = 0;
  logic [7:0] model [8192];
  logic [12:0] addrList [16];

  always #2 clk = ~clk;

  byte_sram_ctl u0 (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .dataIn(dataIn), .ceN(ceN),
    .weN(weN), .oeN(oeN), .wrProtect(wrProtect), .dataOut(dataOut),
    .dataDrive(dataDrive), .protoErr(protoErr)
  );

  always @(posedge clk) if (protoErr === 1'b1) errPulses++;

  function automatic logic [7:0] expRead(input logic [12:0] a);
    return model[a];
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [12:0] a, input logic [7:0] d);
    addrIn = a; dataIn = d; oeN = 1'b1; ceN = 1'b0; weN = 1'b0;
    tick(3);
    weN = 1'b1; ceN = 1'b1;
    tick(5);
    if (!wrProtect) model[a] = d;
  endtask

  task automatic doRead(input logic [12:0] a, input string tag);
    addrIn = a; ceN = 1'b0; oeN = 1'b0; weN = 1'b1;
    tick(3);
    chk(dataDrive === 1'b1, tag, int'(dataDrive), 1);
    chk(dataOut === expRead(a), tag, int'(dataOut), int'(expRead(a)));
    ceN = 1'b1; oeN = 1'b1;
    tick(1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int e0;
    void'($urandom(32'h5eed));
    tick(3);
    // R10: reset state
    chk(dataDrive === 1'b0, "R10 drive", int'(dataDrive), 0);
    chk(dataOut === 8'h00, "R10 out", int'(dataOut), 0);
    chk(protoErr === 1'b0, "R10 err", int'(protoErr), 0);
    rstN = 1'b1;
    tick(2);

    // R1: random writes then read-back
    for (int i = 0; i < 16; i++) addrList[i] = 13'($urandom_range(8191));
    for (int i = 0; i < 40; i++) doWrite(addrList[$urandom_range(15)], 8'($urandom));
    for (int i = 0; i < 16; i++) doRead(addrList[i], "R1 readback");

    // R9: end addresses are independent
    doWrite(13'd0, 8'hA5);
    doWrite(13'd8191, 8'h5A);
    doRead(13'd0, "R9 addr0");
    doRead(13'd8191, "R9 addrMax");

    // R2: window closed by chip enable (write enable low first)
    addrIn = 13'd100; dataIn = 8'h3C; weN = 1'b0; tick(1);
    ceN = 1'b0; tick(3); ceN = 1'b1; tick(1); weN = 1'b1; tick(5);
    model[100] = 8'h3C;
    doRead(13'd100, "R2 ce-closed write");

    // R3: output enable low during a write does not drive
    addrIn = 13'd101; dataIn = 8'h77; oeN = 1'b0; ceN = 1'b0; weN = 1'b0;
    tick(3);
    chk(dataDrive === 1'b0, "R3 drive during write", int'(dataDrive), 0);
    weN = 1'b1; ceN = 1'b1; oeN = 1'b1; tick(5);
    model[101] = 8'h77;
    doRead(13'd101, "R3 write with oe low stored");

    // R4: oe high or ce high releases the bus
    addrIn = 13'd101; ceN = 1'b0; oeN = 1'b1; weN = 1'b1; tick(3);
    chk(dataDrive === 1'b0, "R4 oe high drive", int'(dataDrive), 0);
    chk(dataOut === 8'h00, "R4 oe high out", int'(dataOut), 0);
    ceN = 1'b1; oeN = 1'b0; tick(3);
    chk(dataDrive === 1'b0, "R4 ce high drive", int'(dataDrive), 0);
    oeN = 1'b1; tick(1);

    // R5: protection blocks writes, reads and errors
    wrProtect = 1'b1; tick(1);
    e0 = errPulses;
    doWrite(13'd100, 8'hEE);
    addrIn = 13'd100; ceN = 1'b0; oeN = 1'b0; tick(3);
    chk(dataDrive === 1'b0, "R5 drive under protect", int'(dataDrive), 0);
    ceN = 1'b0; weN = 1'b0; oeN = 1'b1; tick(2); weN = 1'b1; tick(1);
    weN = 1'b0; tick(2); weN = 1'b1; ceN = 1'b1; tick(2);
    chk(errPulses == e0, "R5 no error under protect", errPulses - e0, 0);
    wrProtect = 1'b0; tick(5);
    doRead(13'd100, "R5 byte unchanged");

    // R6: recovery too short (weN high 2 edges) rejected
    e0 = errPulses;
    addrIn = 13'd200; dataIn = 8'h11; ceN = 1'b0; weN = 1'b0; tick(3);
    weN = 1'b1; tick(2);
    dataIn = 8'h22; weN = 1'b0; tick(3); weN = 1'b1; ceN = 1'b1; tick(5);
    model[200] = 8'h11;
    chk(errPulses - e0 == 1, "R6 error pulse", errPulses - e0, 1);
    doRead(13'd200, "R6 rejected write ignored");
    // R6: boundary, REC_CYC edges high is still rejected
    e0 = errPulses;
    ceN = 1'b0; weN = 1'b0; dataIn = 8'h33; tick(3);
    weN = 1'b1; tick(3);
    dataIn = 8'h44; weN = 1'b0; tick(3); weN = 1'b1; ceN = 1'b1; tick(5);
    model[200] = 8'h33;
    chk(errPulses - e0 == 1, "R6 boundary reject", errPulses - e0, 1);
    doRead(13'd200, "R6 boundary reject data");
    // R6: REC_CYC+1 edges high is accepted
    e0 = errPulses;
    ceN = 1'b0; weN = 1'b0; dataIn = 8'h55; tick(3);
    weN = 1'b1; tick(4);
    dataIn = 8'h66; weN = 1'b0; tick(3); weN = 1'b1; ceN = 1'b1; tick(5);
    model[200] = 8'h66;
    chk(errPulses == e0, "R6 boundary accept", errPulses - e0, 0);
    doRead(13'd200, "R6 accepted write");

    // R7: protection mid-window aborts the whole window
    addrIn = 13'd300; dataIn = 8'h99; ceN = 1'b0; weN = 1'b0; tick(1);
    wrProtect = 1'b1; tick(2); wrProtect = 1'b0; tick(2);
    weN = 1'b1; ceN = 1'b1; tick(5);
    doWrite(13'd301, 8'h01);
    model[300] = 8'h00;
    doWrite(13'd300, 8'h00);
    addrIn = 13'd300; dataIn = 8'hC3; ceN = 1'b0; weN = 1'b0; tick(1);
    wrProtect = 1'b1; tick(2); wrProtect = 1'b0; tick(2);
    weN = 1'b1; ceN = 1'b1; tick(5);
    doRead(13'd300, "R7 aborted window");

    // R8: last data value in the window is stored
    addrIn = 13'd400; dataIn = 8'h10; ceN = 1'b0; weN = 1'b0; tick(2);
    dataIn = 8'h20; tick(2); weN = 1'b1; ceN = 1'b1; tick(5);
    model[400] = 8'h20;
    doRead(13'd400, "R8 last data stored");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule